// File: doc/BRIEF.md
# Flash Command Register Decoder

This block is a synchronous model of the command front end of a byte-wide, bulk-erase flash memory. It samples the active-low chip enable, output enable and write enable strobes together with the address and data buses. From the write cycles it sees, it decodes one- and two-byte command sequences into an operating mode. An input `hv_en` stands for the presence of the high programming voltage. While it is low, the decoder sits in read mode and ignores every write.

Erase and program are run as pulses. A start pulse goes to the array side, an internal stop timer limits the pulse length, and a stop pulse marks its end. The pulse ends either when the matching verify command arrives or when the timer runs out. The array is reached through a plain RAM port. The RAM returns read data combinationally, writes one byte when `mem_we` is high, and clears itself to FFh on `erase_start`. Reads return array data, or in identification mode one of two fixed ID bytes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write cycle is taken only while `ce_n` and `we_n` are both low and `oe_n` is high. A strobe pattern with `oe_n` low or with `ce_n` high changes nothing, and the mode stays 0 (read).
- R2: The command address is taken in the cycle where the later of `we_n`/`ce_n` falls. The data byte is taken when the first of them rises, so a data change during the low phase is honoured and an address change after the later fall is not.
- R3: While `hv_en` is low, `mode` is 0 (read) from the next cycle on and writes have no effect. When `hv_en` returns high, the block is still in mode 0.
- R4: After reset `mode` is 0 (read), `dq_oe` is low and neither pulse is busy. Byte 00h selects mode 0. Byte FFh selects mode 8 (reset armed), and a second FFh returns to mode 0. In mode 0 a read returns the array byte at `addr`.
- R5: Bytes 80h and 90h select mode 1 (identification). In mode 1 a read with `addr[0]`=0 returns 01h and a read with `addr[0]`=1 returns 2Ah.
- R6: Both identification bytes have odd parity over all eight bits, with bit 7 as the parity bit.
- R7: Byte 20h selects mode 2 (erase armed) and leaves the array untouched. A second 20h enters mode 3 (erasing) and issues a one-cycle `erase_start`.
- R8: Byte A0h selects mode 4 (erase verify) and latches the write address. Any write made during mode 3 ends a running erase with an `erase_stop` pulse. In mode 4 reads return the array byte at the latched address, whatever `addr` is.
- R9: Byte 40h selects mode 5 (program armed). The next write enters mode 6 (programming), issues `prog_start`, and writes its data byte at its address through `mem_we`. A following C0h ends the pulse with `prog_stop`, selects mode 7, and reads then return the programmed byte.
- R10: With no further write, `erase_busy` stays high for exactly ERASE_CYC cycles and `prog_busy` for exactly PROG_CYC cycles. Each then gives its stop pulse on its own, and the mode does not change.
- R11: Any command byte other than 00h, FFh, 80h, 90h, 20h, A0h, 40h or C0h, written as a first byte, selects mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hv_en | input | 1 | High programming voltage present |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Address bus |
| dq_in | input | 8 | Data bus into the device |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Read data is driven |
| mode | output | 4 | Current mode code |
| erase_start | output | 1 | One-cycle start of the bulk erase pulse |
| erase_stop | output | 1 | One-cycle end of the erase pulse |
| erase_busy | output | 1 | Erase pulse running |
| prog_start | output | 1 | One-cycle start of the program pulse |
| prog_stop | output | 1 | One-cycle end of the program pulse |
| prog_busy | output | 1 | Program pulse running |
| mem_addr | output | AW | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array byte write |
| mem_rdata | input | 8 | Array read data |

## Verification
A wrong mode register appears on `mode` two cycles after the strobe rise that carried the command. It then shows up again on the first read, which returns an ID byte, array data or a verify byte that differs from the expected one. A wrong latched address or data byte shows up only on the next read in a verify mode, or as a byte written at the wrong place in the array. A stop timer that runs long or short changes the number of `*_busy` cycles, so the cycle count between start and stop pulses exposes it within one pulse length.

// File: rtl/fcd_pkg.sv
// Shared codes for the flash command decoder: mode encoding, command bytes, ID bytes.
package fcd_pkg;

    typedef enum logic [3:0] {
        MD_READ        = 4'd0,
        MD_ID          = 4'd1,
        MD_ERA_ARM     = 4'd2,
        MD_ERASING     = 4'd3,
        MD_ERA_VFY     = 4'd4,
        MD_PRG_ARM     = 4'd5,
        MD_PROGRAMMING = 4'd6,
        MD_PRG_VFY     = 4'd7,
        MD_RST_ARM     = 4'd8
    } mode_t;

    localparam logic [7:0] CMD_READ  = 8'h00;
    localparam logic [7:0] CMD_RESET = 8'hFF;
    localparam logic [7:0] CMD_ID_A  = 8'h80;
    localparam logic [7:0] CMD_ID_B  = 8'h90;
    localparam logic [7:0] CMD_ERASE = 8'h20;
    localparam logic [7:0] CMD_EVFY  = 8'hA0;
    localparam logic [7:0] CMD_PROG  = 8'h40;
    localparam logic [7:0] CMD_PVFY  = 8'hC0;

    localparam logic [7:0] ID_MAKER  = 8'h01;
    localparam logic [7:0] ID_DEVICE = 8'h2A;

endpackage

// File: rtl/fcd_write_capture.sv
// Write-cycle capture.
// Turns the sampled strobes into a one-cycle write event carrying address and data.
// Assumes the strobes are already synchronous to clk. The address is held from the
// cycle the write condition starts (the later strobe fall). The data is taken in the
// cycle the condition ends (the earlier strobe rise).
module fcd_write_capture #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hv_en,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    dq_in,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);

    logic          act;
    logic          act_q;
    logic [AW-1:0] addr_hold;

    // Write condition: both enables low, outputs off, high voltage present.
    assign act = hv_en & ~ce_n & ~we_n & oe_n;

    // Track the condition, hold the address at its start, emit the event at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q     <= 1'b0;
            addr_hold <= '0;
            wr_stb    <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            act_q  <= act;
            wr_stb <= 1'b0;
            if (act && !act_q) begin
                addr_hold <= addr;
            end
            if (!act && act_q && hv_en) begin
                wr_stb  <= 1'b1;
                wr_addr <= addr_hold;
                wr_data <= dq_in;
            end
        end
    end

endmodule

// File: rtl/fcd_cmd_fsm.sv
// Command sequencer.
// Decodes write events into modes. It holds the verify address and the program
// address/data, and issues start and halt requests for the erase and program pulses.
// Assumes at most one write event per two cycles. A low hv_en forces read mode.
module fcd_cmd_fsm
    import fcd_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hv_en,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output mode_t         mode,
    output logic [AW-1:0] vfy_addr,
    output logic [AW-1:0] prog_addr,
    output logic [7:0]    prog_data,
    output logic          erase_go,
    output logic          erase_halt,
    output logic          prog_go,
    output logic          prog_halt
);

    mode_t         dec_mode;
    mode_t         nxt_mode;
    logic [AW-1:0] dec_vfy;
    logic [AW-1:0] nxt_vfy;
    logic [AW-1:0] nxt_pa;
    logic [7:0]    nxt_pd;
    logic          nxt_ego;
    logic          nxt_pgo;
    logic          nxt_ehalt;
    logic          nxt_phalt;

    // First-byte decode of the incoming data byte.
    always_comb begin
        dec_vfy = vfy_addr;
        case (wr_data)
            CMD_READ:           dec_mode = MD_READ;
            CMD_RESET:          dec_mode = MD_RST_ARM;
            CMD_ID_A, CMD_ID_B: dec_mode = MD_ID;
            CMD_ERASE:          dec_mode = MD_ERA_ARM;
            CMD_EVFY: begin
                dec_mode = MD_ERA_VFY;
                dec_vfy  = wr_addr;
            end
            CMD_PROG:           dec_mode = MD_PRG_ARM;
            CMD_PVFY: begin
                dec_mode = MD_PRG_VFY;
                dec_vfy  = prog_addr;
            end
            default:            dec_mode = MD_READ;
        endcase
    end

    // Next state: second bytes of armed sequences override the first-byte decode.
    always_comb begin
        nxt_mode  = mode;
        nxt_vfy   = vfy_addr;
        nxt_pa    = prog_addr;
        nxt_pd    = prog_data;
        nxt_ego   = 1'b0;
        nxt_pgo   = 1'b0;
        nxt_ehalt = wr_stb && (mode == MD_ERASING);
        nxt_phalt = wr_stb && (mode == MD_PROGRAMMING);
        if (wr_stb) begin
            nxt_mode = dec_mode;
            nxt_vfy  = dec_vfy;
            case (mode)
                MD_ERA_ARM: begin
                    if (wr_data == CMD_ERASE) begin
                        nxt_mode = MD_ERASING;
                        nxt_ego  = 1'b1;
                    end
                end
                MD_PRG_ARM: begin
                    nxt_mode = MD_PROGRAMMING;
                    nxt_vfy  = vfy_addr;
                    nxt_pa   = wr_addr;
                    nxt_pd   = wr_data;
                    nxt_pgo  = 1'b1;
                end
                MD_RST_ARM: begin
                    if (wr_data == CMD_RESET) begin
                        nxt_mode = MD_READ;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // State register; a low high-voltage enable holds read mode and drops requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= MD_READ;
            vfy_addr   <= '0;
            prog_addr  <= '0;
            prog_data  <= '0;
            erase_go   <= 1'b0;
            erase_halt <= 1'b0;
            prog_go    <= 1'b0;
            prog_halt  <= 1'b0;
        end else if (!hv_en) begin
            mode       <= MD_READ;
            erase_go   <= 1'b0;
            erase_halt <= 1'b0;
            prog_go    <= 1'b0;
            prog_halt  <= 1'b0;
        end else begin
            mode       <= nxt_mode;
            vfy_addr   <= nxt_vfy;
            prog_addr  <= nxt_pa;
            prog_data  <= nxt_pd;
            erase_go   <= nxt_ego;
            erase_halt <= nxt_ehalt;
            prog_go    <= nxt_pgo;
            prog_halt  <= nxt_phalt;
        end
    end

endmodule

// File: rtl/fcd_pulse_timer.sv
// Stop timer for one pulse.
// start raises busy. busy falls after CYC cycles or one cycle after halt, and the
// fall gives a one-cycle done. Assumes CYC >= 1.
module fcd_pulse_timer #(
    parameter int CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic halt,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    // Count busy cycles and end the pulse on halt or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (halt || cnt == CW'(CYC - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Flash command decoder top.
// Wires write capture, command sequencer and the two pulse timers, and forms the
// read path and the array port. Assumes mem_rdata is a combinational function of
// mem_addr. Reads are served in every mode, with or without high voltage.
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int AW        = 18,
    parameter int ERASE_CYC = 1000,
    parameter int PROG_CYC  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hv_en,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    dq_in,
    output logic [7:0]    dq_out,
    output logic          dq_oe,
    output logic [3:0]    mode,
    output logic          erase_start,
    output logic          erase_stop,
    output logic          erase_busy,
    output logic          prog_start,
    output logic          prog_stop,
    output logic          prog_busy,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    input  logic [7:0]    mem_rdata
);

    logic          wr_stb;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    mode_t         cur_mode;
    logic [AW-1:0] vfy_addr;
    logic [AW-1:0] prog_addr;
    logic [7:0]    prog_data;
    logic          erase_halt;
    logic          prog_halt;
    logic          in_verify;

    fcd_write_capture #(.AW(AW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .hv_en   (hv_en),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .addr    (addr),
        .dq_in   (dq_in),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    fcd_cmd_fsm #(.AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hv_en      (hv_en),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .mode       (cur_mode),
        .vfy_addr   (vfy_addr),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .erase_go   (erase_start),
        .erase_halt (erase_halt),
        .prog_go    (prog_start),
        .prog_halt  (prog_halt)
    );

    fcd_pulse_timer #(.CYC(ERASE_CYC)) u_erase_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (erase_start),
        .halt  (erase_halt | ~hv_en),
        .busy  (erase_busy),
        .done  (erase_stop)
    );

    fcd_pulse_timer #(.CYC(PROG_CYC)) u_prog_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_start),
        .halt  (prog_halt | ~hv_en),
        .busy  (prog_busy),
        .done  (prog_stop)
    );

    // Array port: program writes take the latched address, verify modes the verify address.
    assign in_verify = (cur_mode == MD_ERA_VFY) || (cur_mode == MD_PRG_VFY);
    assign mem_we    = prog_start;
    assign mem_wdata = prog_data;
    assign mem_addr  = mem_we ? prog_addr : (in_verify ? vfy_addr : addr);

    // Read path: ID bytes in identification mode, array data otherwise.
    assign dq_oe  = ~ce_n & ~oe_n;
    assign dq_out = (cur_mode == MD_ID) ? (addr[0] ? ID_DEVICE : ID_MAKER) : mem_rdata;
    assign mode   = cur_mode;

endmodule

// File: rtl/fcd_checker.sv
// Property checker for the flash command decoder, bound to every instance of the top.
module fcd_checker #(
    parameter int ERASE_CYC = 1000,
    parameter int PROG_CYC  = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hv_en,
    input logic [3:0] mode,
    input logic [7:0] dq_out,
    input logic       dq_oe,
    input logic       erase_start,
    input logic       erase_busy,
    input logic       prog_start,
    input logic       prog_busy
);

    logic [31:0] e_run;
    logic [31:0] p_run;

    // Count consecutive busy cycles of each pulse for the length bound.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_run <= '0;
            p_run <= '0;
        end else begin
            e_run <= erase_busy ? e_run + 1 : 32'd0;
            p_run <= prog_busy  ? p_run + 1 : 32'd0;
        end
    end

    a_r3_low_hv_reads: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_en |=> mode == 4'd0);

    a_r10_erase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |-> e_run < 32'(ERASE_CYC));

    a_r10_prog_bound: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> p_run < 32'(PROG_CYC));

    a_r7_erase_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_busy) |-> $past(erase_start));

    a_r9_prog_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_busy) |-> $past(prog_start));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_busy && prog_busy));

    a_r6_id_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd1 && dq_oe) |-> (^dq_out));

endmodule

bind flash_cmd_decoder fcd_checker #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hv_en       (hv_en),
    .mode        (mode),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe),
    .erase_start (erase_start),
    .erase_busy  (erase_busy),
    .prog_start  (prog_start),
    .prog_busy   (prog_busy)
);

// File: tb/sim_flash_cmd_decoder.sv
// Scoreboard bench: driver tasks queue expected read bytes, a monitor compares them.
module sim_flash_cmd_decoder;

    localparam int CLK_P     = 10;
    localparam int AW        = 4;
    localparam int DEPTH     = 1 << AW;
    localparam int ERASE_CYC = 40;
    localparam int PROG_CYC  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hv_en = 1'b1;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_in = '0;
    logic [7:0]    dq_out;
    logic          dq_oe;
    logic [3:0]    mode;
    logic          erase_start, erase_stop, erase_busy;
    logic          prog_start, prog_stop, prog_busy;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_we;
    logic [7:0]    mem_rdata;

    logic [7:0]    arr [DEPTH];
    int            n_chk = 0;
    int            n_bad = 0;
    int            e_starts = 0, e_stops = 0, p_starts = 0, p_stops = 0;
    int            e_busy_n = 0, p_busy_n = 0;
    int            base;
    logic          rd_req = 1'b0;
    logic [7:0]    exp_q [$];
    string         tag_q [$];

    always #(CLK_P / 2) clk = ~clk;

    flash_cmd_decoder #(.AW(AW), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .mode(mode),
        .erase_start(erase_start), .erase_stop(erase_stop), .erase_busy(erase_busy),
        .prog_start(prog_start), .prog_stop(prog_stop), .prog_busy(prog_busy),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    // Array model: combinational read, byte write, bulk erase to FFh.
    assign mem_rdata = arr[mem_addr];
    initial for (int i = 0; i < DEPTH; i++) arr[i] = 8'h30 + 8'(i);
    always @(posedge clk) begin
        if (erase_start) for (int i = 0; i < DEPTH; i++) arr[i] <= 8'hFF;
        if (mem_we) arr[mem_addr] <= mem_wdata;
    end

    // Event counters sampled at the falling edge.
    always @(negedge clk) begin
        e_starts <= e_starts + int'(erase_start);
        e_stops  <= e_stops  + int'(erase_stop);
        p_starts <= p_starts + int'(prog_start);
        p_stops  <= p_stops  + int'(prog_stop);
        e_busy_n <= e_busy_n + int'(erase_busy);
        p_busy_n <= p_busy_n + int'(prog_busy);
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
        cyc(2); we_n = 1'b1; ce_n = 1'b1;
        cyc(2);
    endtask

    task automatic wr_oe_low(input logic [7:0] d);
        @(negedge clk); dq_in = d; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        cyc(2); we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        cyc(2);
    endtask

    task automatic wr_we_only(input logic [7:0] d);
        @(negedge clk); dq_in = d; we_n = 1'b0;
        cyc(2); we_n = 1'b1;
        cyc(2);
    endtask

    task automatic wr_addr_move(input logic [AW-1:0] a1, input logic [AW-1:0] a2,
                                input logic [7:0] d);
        @(negedge clk); addr = a1; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); addr = a2;
        @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
        cyc(2);
    endtask

    // Chip-enable-timed write: we_n falls first, ce_n falls later and rises first.
    task automatic wr_ce_timed(input logic [AW-1:0] a_we, input logic [AW-1:0] a_ce,
                               input logic [7:0] d1, input logic [7:0] d2);
        @(negedge clk); addr = a_we; dq_in = d1; we_n = 1'b0;
        @(negedge clk); addr = a_ce; ce_n = 1'b0;
        @(negedge clk); addr = a_we; dq_in = d2;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk); we_n = 1'b1;
        cyc(2);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic id_parity(input logic [AW-1:0] a);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #1 check("R6 id parity", int'(^dq_out), 1);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    endtask

    // Monitor: pops one expected byte per read request, a quarter period after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P / 4);
            if (rd_req) begin
                check({tag_q[0], " dq_oe"}, int'(dq_oe), 1);
                check(tag_q.pop_front(), int'(dq_out), int'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R4 reset state
        check("R4 reset mode", int'(mode), 0);
        check("R4 reset dq_oe", int'(dq_oe), 0);
        check("R4 reset busy", int'(erase_busy | prog_busy), 0);

        // R5 identification bytes, R6 parity
        wr(0, 8'h90);
        check("R5 mode id", int'(mode), 1);
        rd(0, 8'h01, "R5 maker byte");
        rd(1, 8'h2A, "R5 device byte");
        id_parity(0);
        id_parity(1);
        wr(0, 8'h80);
        rd(3, 8'h2A, "R5 80h selects id");

        // R4 read command and double reset byte
        wr(0, 8'h00);
        check("R4 00h mode", int'(mode), 0);
        rd(3, 8'h33, "R4 array read");
        wr(0, 8'h90);
        wr(0, 8'hFF);
        check("R4 first FFh armed", int'(mode), 8);
        wr(0, 8'hFF);
        check("R4 second FFh read", int'(mode), 0);
        rd(1, 8'h31, "R4 read after reset");

        // R11 unknown byte
        wr(0, 8'h90);
        wr(0, 8'h37);
        check("R11 unknown byte", int'(mode), 0);
        rd(2, 8'h32, "R11 array read");

        // R1 gated strobes
        wr_oe_low(8'h90);
        check("R1 oe low ignored", int'(mode), 0);
        wr_we_only(8'h90);
        check("R1 ce high ignored", int'(mode), 0);
        rd(0, 8'h30, "R1 still array");

        // R7 single erase byte
        wr(0, 8'h20);
        check("R7 erase armed", int'(mode), 2);
        cyc(3);
        check("R7 no start", e_starts, 0);
        wr(0, 8'h00);
        rd(4, 8'h34, "R7 array untouched");

        // R3 high voltage removed
        wr(0, 8'h90);
        hv_en = 1'b0;
        cyc(2);
        check("R3 forced read", int'(mode), 0);
        wr(0, 8'h90);
        check("R3 write ignored", int'(mode), 0);
        rd(0, 8'h30, "R3 array read");
        hv_en = 1'b1;
        cyc(2);
        check("R3 read after rise", int'(mode), 0);

        // R7 erase start, R8 halted by verify byte
        wr(0, 8'h20);
        wr(0, 8'h20);
        check("R7 erasing", int'(mode), 3);
        cyc(2);
        check("R7 one start", e_starts, 1);
        check("R7 busy", int'(erase_busy), 1);
        wr(6, 8'hA0);
        cyc(2);
        check("R8 stop pulse", e_stops, 1);
        check("R8 busy cleared", int'(erase_busy), 0);
        check("R8 verify mode", int'(mode), 4);
        rd(9, 8'hFF, "R8 verify byte");

        // R10 erase timer expiry
        base = e_busy_n;
        wr(0, 8'h20);
        wr(0, 8'h20);
        cyc(60);
        check("R10 erase length", e_busy_n - base, ERASE_CYC);
        check("R10 erase self stop", e_stops, 2);
        check("R10 erase mode kept", int'(mode), 3);

        // R9 program and program verify
        wr(0, 8'h40);
        check("R9 program armed", int'(mode), 5);
        wr(5, 8'h5A);
        cyc(1);
        check("R9 programming", int'(mode), 6);
        check("R9 start", p_starts, 1);
        check("R9 busy", int'(prog_busy), 1);
        wr(0, 8'hC0);
        cyc(2);
        check("R9 stop", p_stops, 1);
        check("R9 verify mode", int'(mode), 7);
        rd(0, 8'h5A, "R9 programmed byte");

        // R2 address taken at the strobe fall
        wr_addr_move(5, 7, 8'hA0);
        rd(0, 8'h5A, "R2 address at fall");

        // R10 program timer expiry
        base = p_busy_n;
        wr(0, 8'h40);
        wr(2, 8'h22);
        cyc(30);
        check("R10 program length", p_busy_n - base, PROG_CYC);
        check("R10 program self stop", p_stops, 2);
        check("R10 program mode kept", int'(mode), 6);
        wr(0, 8'h00);
        rd(2, 8'h22, "R9 second program byte");

        // R2 chip-enable timed write: later fall address, earlier rise data
        wr_ce_timed(2, 5, 8'h11, 8'hA0);
        check("R2 data at rise", int'(mode), 4);
        rd(0, 8'h5A, "R2 address at later fall");

        cyc(3);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule